// File: doc/BRIEF.md
# Reversible Biquinary Decade Counter

This block is a synchronous decade counter that counts up or down in biquinary code. Its state is a one-bit "half" stage that toggles on every accepted count, and a one-hot ring of five positions. The ring advances only when the half stage rolls over in the direction of counting. The decimal value is twice the index of the active ring position plus the half bit.

Up and down requests arrive asynchronously. Each request passes through a synchronizer and then an edge detector, which turns it into a pulse exactly one clock long. That pulse is combined with the currently active ring position to prime the neighbouring position, and the state changes on the following clock edge. The counter reports its state in two forms: as the raw biquinary state, and as a ten-line one-hot digit readout built from two-input AND terms. Carry and borrow pulses are provided for chaining decades.

Top module: `bq_decade_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes digit 0: `quin_o` = 5'b00001, `bin_o` = 0 and `digit_o` = 10'b0000000001.
- R2: Bit i of `quin_o` (i = 0..4) marks ring position i. The represented digit is 2*i + `bin_o`.
- R3: Every accepted count, whether up or down, inverts `bin_o` on the next clock edge.
- R4: An accepted up count moves the ring one position upward (bit 4 wraps to bit 0), but only if `bin_o` was 1 before the edge. Otherwise the ring holds.
- R5: An accepted down count moves the ring one position downward (bit 0 wraps to bit 4), but only if `bin_o` was 0 before the edge. Otherwise the ring holds.
- R6: A request input passes through two synchronizer flops and then an edge detector. A rising edge on the request produces exactly one count, however long the request is held. The new state appears at the ports after the third clock edge that follows the request going high.
- R7: Exactly one bit of `quin_o` is set at all times after reset. An illegal ring pattern returns to position 0 on the next edge.
- R8: `digit_o` is one-hot. Bit d is set exactly when the represented digit is d.
- R9: `carry_o` is high for the single clock in which an up count is taken at digit 9, and the counter then shows digit 0.
- R10: `borrow_o` is high for the single clock in which a down count is taken at digit 0, and the counter then shows digit 9.
- R11: If up and down counts become pulses in the same cycle, neither is taken. Both state outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous reset, active high |
| req_up_i | input | 1 | Asynchronous up-count request, counted on its rising edge |
| req_dn_i | input | 1 | Asynchronous down-count request, counted on its rising edge |
| bin_o | output | 1 | Half stage (least significant part of the digit) |
| quin_o | output | 5 | One-hot ring position |
| digit_o | output | 10 | One-hot decimal readout |
| carry_o | output | 1 | One-clock pulse on an up count out of digit 9 |
| borrow_o | output | 1 | One-clock pulse on a down count out of digit 0 |

## Verification
The readout is decoded combinationally from the state flops. A half stage or ring position that is set wrongly therefore shows on `digit_o` in the same cycle, either as the wrong bit or as a pattern that is not one-hot. A fault in the synchronizer or the edge detector shows as the wrong number of counts: two counts, or none, three clocks after a request. A ring that moves on the wrong half-stage value drifts from a decimal reference model after the next rollover, and a faulty carry or borrow is caught at the wrap between digits 9 and 0.

// File: rtl/bq_pkg.sv
package bq_pkg;
  localparam int QN = 5;
  localparam int DN = 2 * QN;
  typedef logic [QN-1:0] quin_t;
  typedef logic [DN-1:0] digit_t;

  // ring one step upward: position i takes position i-1
  function automatic quin_t ring_up(quin_t q);
    return {q[QN-2:0], q[QN-1]};
  endfunction

  // ring one step downward: position i takes position i+1
  function automatic quin_t ring_down(quin_t q);
    return {q[0], q[QN-1:1]};
  endfunction
endpackage

// File: rtl/bq_req_sync.sv
module bq_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], req_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  // one clock long per rising edge of the synchronized request
  assign pulse_o = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/bq_binary_stage.sv
module bq_binary_stage (
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  output logic bin_o
);
  always_ff @(posedge clk) begin
    if (rst)         bin_o <= 1'b0;
    else if (step_i) bin_o <= ~bin_o;
  end
endmodule

// File: rtl/bq_quinary_ring.sv
module bq_quinary_ring #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fwd_i,
  input  logic         bwd_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] prime_fwd, prime_bwd, nxt;
  logic         legal;

  generate
    for (genvar i = 0; i < N; i++) begin : g_pos
      localparam int LO = (i + N - 1) % N;
      localparam int HI = (i + 1) % N;
      assign prime_fwd[i] = fwd_i & q_o[LO];
      assign prime_bwd[i] = bwd_i & q_o[HI];
      assign nxt[i] = prime_fwd[i] | prime_bwd[i] | (q_o[i] & ~fwd_i & ~bwd_i);
    end
  endgenerate

  assign legal = ($countones(q_o) == 1);

  always_ff @(posedge clk) begin
    if (rst || !legal) q_o <= {{(N-1){1'b0}}, 1'b1};
    else               q_o <= nxt;
  end
endmodule

// File: rtl/bq_readout.sv
module bq_readout #(
  parameter int N = 5
) (
  input  logic           bin_i,
  input  logic [N-1:0]   q_i,
  output logic [2*N-1:0] digit_o
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_and
      assign digit_o[2*i]   = q_i[i] & ~bin_i;
      assign digit_o[2*i+1] = q_i[i] &  bin_i;
    end
  endgenerate
endmodule

// File: rtl/bq_decade_counter.sv
module bq_decade_counter
  import bq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_up_i,
  input  logic          req_dn_i,
  output logic          bin_o,
  output logic [QN-1:0] quin_o,
  output logic [DN-1:0] digit_o,
  output logic          carry_o,
  output logic          borrow_o
);
  // named internal events, observed by the checker
  logic pulse_up, pulse_dn;
  logic take_up, take_dn, take_any;
  logic ring_fwd, ring_bwd;

  bq_req_sync #(.STAGES(SYNC_STAGES)) u_sync_up (
    .clk(clk), .rst(rst), .req_i(req_up_i), .pulse_o(pulse_up));
  bq_req_sync #(.STAGES(SYNC_STAGES)) u_sync_dn (
    .clk(clk), .rst(rst), .req_i(req_dn_i), .pulse_o(pulse_dn));

  assign take_up  = pulse_up & ~pulse_dn;
  assign take_dn  = pulse_dn & ~pulse_up;
  assign take_any = take_up | take_dn;
  assign ring_fwd = take_up & bin_o;
  assign ring_bwd = take_dn & ~bin_o;

  bq_binary_stage u_bin (
    .clk(clk), .rst(rst), .step_i(take_any), .bin_o(bin_o));

  bq_quinary_ring #(.N(QN)) u_ring (
    .clk(clk), .rst(rst), .fwd_i(ring_fwd), .bwd_i(ring_bwd), .q_o(quin_o));

  bq_readout #(.N(QN)) u_read (
    .bin_i(bin_o), .q_i(quin_o), .digit_o(digit_o));

  assign carry_o  = ring_fwd & quin_o[QN-1];
  assign borrow_o = ring_bwd & quin_o[0];
endmodule

// File: rtl/bq_decade_checker.sv
module bq_decade_checker
  import bq_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          bin_o,
  input logic [QN-1:0] quin_o,
  input logic [DN-1:0] digit_o,
  input logic          carry_o,
  input logic          borrow_o,
  input logic          pulse_up,
  input logic          pulse_dn,
  input logic          take_up,
  input logic          take_dn
);
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (quin_o == quin_t'(1)) && !bin_o);

  a_r3_half_toggles: assert property (@(posedge clk) disable iff (rst)
    (take_up || take_dn) |=> bin_o != $past(bin_o));

  a_r4_ring_up: assert property (@(posedge clk) disable iff (rst)
    (take_up && bin_o) |=> quin_o == ring_up($past(quin_o)));

  a_r4_ring_up_hold: assert property (@(posedge clk) disable iff (rst)
    (take_up && !bin_o) |=> $stable(quin_o));

  a_r5_ring_down: assert property (@(posedge clk) disable iff (rst)
    (take_dn && !bin_o) |=> quin_o == ring_down($past(quin_o)));

  a_r5_ring_down_hold: assert property (@(posedge clk) disable iff (rst)
    (take_dn && bin_o) |=> $stable(quin_o));

  a_r6_pulse_single: assert property (@(posedge clk) disable iff (rst)
    pulse_up |=> !pulse_up);

  a_r6_pulse_single_dn: assert property (@(posedge clk) disable iff (rst)
    pulse_dn |=> !pulse_dn);

  a_r7_ring_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(quin_o) == 1);

  a_r8_readout_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(digit_o) && (digit_o != '0));

  a_r9_carry_wraps: assert property (@(posedge clk) disable iff (rst)
    carry_o |=> digit_o[0]);

  a_r10_borrow_wraps: assert property (@(posedge clk) disable iff (rst)
    borrow_o |=> digit_o[DN-1]);

  a_r11_both_ignored: assert property (@(posedge clk) disable iff (rst)
    (pulse_up && pulse_dn) |=> $stable(quin_o) && $stable(bin_o));
endmodule

bind bq_decade_counter bq_decade_checker u_chk (
  .clk(clk), .rst(rst), .bin_o(bin_o), .quin_o(quin_o), .digit_o(digit_o),
  .carry_o(carry_o), .borrow_o(borrow_o), .pulse_up(pulse_up),
  .pulse_dn(pulse_dn), .take_up(take_up), .take_dn(take_dn));

// File: tb/tb_bq_decade_counter.sv
module tb_bq_decade_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_up_i = 1'b0, req_dn_i = 1'b0;
  logic       bin_o;
  logic [4:0] quin_o;
  logic [9:0] digit_o;
  logic       carry_o, borrow_o;

  int errors = 0, checks = 0;
  int ref_d = 0;
  int carries = 0, borrows = 0;

  always #2 clk = ~clk;

  bq_decade_counter dut (.*);

  // carry/borrow high-cycle counters, sampled away from the active edge
  always @(negedge clk) begin
    if (carry_o)  carries++;
    if (borrow_o) borrows++;
  end

  function automatic logic [4:0] exp_quin(int d);
    return 5'(1 << (d / 2));
  endfunction
  function automatic logic [9:0] exp_digit(int d);
    return 10'(1 << d);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (ref digit %0d)", req, act, exp, ref_d);
    end
  endtask

  task automatic chk_state(string req);
    chk({req, " R2 ring"}, 32'(quin_o), 32'(exp_quin(ref_d)));
    chk({req, " R3 half"}, 32'(bin_o), 32'(ref_d % 2));
    chk({req, " R8 readout"}, 32'(digit_o), 32'(exp_digit(ref_d)));
  endtask

  // issue one request (up, down or both), held for hold cycles
  task automatic issue(bit up, bit dn, int hold);
    int exp_c, exp_b;
    exp_c = (up && !dn && ref_d == 9) ? 1 : 0;
    exp_b = (dn && !up && ref_d == 0) ? 1 : 0;
    carries = 0; borrows = 0;
    @(negedge clk);
    req_up_i = up; req_dn_i = dn;
    repeat (hold) @(negedge clk);
    req_up_i = 1'b0; req_dn_i = 1'b0;
    repeat (4) @(negedge clk);
    if (up && !dn) ref_d = (ref_d + 1) % 10;
    else if (dn && !up) ref_d = (ref_d + 9) % 10;
    chk("R9 carry count", 32'(carries), 32'(exp_c));
    chk("R10 borrow count", 32'(borrows), 32'(exp_b));
    chk_state(up && dn ? "R11" : (up ? "R4" : "R5"));
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20250611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_state("R1 reset");

    // R6: latency and single count for a long request
    @(negedge clk);
    req_up_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R6 not yet", 32'(digit_o), 32'(exp_digit(0)));
    @(negedge clk);
    chk("R6 third edge", 32'(digit_o), 32'(exp_digit(1)));
    repeat (6) @(negedge clk);
    req_up_i = 1'b0;
    repeat (4) @(negedge clk);
    ref_d = 1;
    chk_state("R6 one count");

    // full up sweep through 9 -> 0 (R4, R9)
    for (int i = 0; i < 10; i++) issue(1'b1, 1'b0, 1 + (i % 3));
    // full down sweep through 0 -> 9 (R5, R10)
    for (int i = 0; i < 10; i++) issue(1'b0, 1'b1, 1 + (i % 2));

    // R10: borrow at digit 0 directly after reset
    rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0; ref_d = 0;
    chk_state("R1 re-reset");
    issue(1'b0, 1'b1, 2);

    // R11: simultaneous requests ignored at several digits
    issue(1'b1, 1'b1, 3);
    issue(1'b1, 1'b0, 1);
    issue(1'b1, 1'b1, 1);

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      int r;
      r = int'($urandom % 8);
      if (r == 0)      issue(1'b1, 1'b1, 1 + int'($urandom % 3));
      else if (r < 5)  issue(1'b1, 1'b0, 1 + int'($urandom % 4));
      else             issue(1'b0, 1'b1, 1 + int'($urandom % 4));
      chk("R7 ring one-hot", 32'($countones(quin_o)), 32'd1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule